// File: doc/BRIEF.md
# Predicate Register File with Compare Writeback

This block keeps a bank of single-bit predicate registers that steer whether an operation's result may be committed. A compare request evaluates a relation between two wide operands and, at the next clock edge, writes the outcome to one named predicate and the inverse outcome to a second named predicate. If/else code can then run both arms without a branch, with each arm gated by one of the two complementary predicates.

Every issued operation names a qualifying predicate. The lookup port returns that predicate's value as a commit-enable, and an operation whose qualifier is clear acts as a no-op. A compare is itself qualified: when its qualifier is clear, no predicate changes. Predicate 0 always reads as one, so an unqualified operation names index 0. Either operand of a compare can be replaced by constant zero, which models a compare against the always-zero integer register.

Top module: `pred_file`

## Requirements
- R1: The file holds NPRED (default 64) predicates. After reset every predicate reads 0, except predicate 0, which reads 1.
- R2: `commit_en` equals the current value of the predicate selected by `op_qp`, with no clock delay.
- R3: A compare with `cmp_valid` high whose qualifier `cmp_qp` names a predicate holding 0 changes no predicate.
- R4: A compare with `cmp_valid` high and a set qualifier writes its result to `cmp_tgt_t` and the inverse of the result to `cmp_tgt_f`. Both values are visible from the clock edge that ends the request cycle.
- R5: The `cmp_rel` encoding is 0 = equal, 1 = not equal, 2 = A less than B as signed numbers, 3 = A greater than B as signed numbers.
- R6: When `cmp_a_zero` (or `cmp_b_zero`) is 1, operand A (or B) is replaced by zero before the relation is evaluated.
- R7: Writes that name predicate 0 are ignored, and predicate 0 keeps reading 1.
- R8: When `cmp_tgt_t` and `cmp_tgt_f` name the same predicate, that predicate receives the result, not its inverse.
- R9: A lookup made in the same cycle as a compare that writes the looked-up predicate returns the old value, because there is no bypass.
- R10: Predicates that a compare does not target keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_valid | input | 1 | Compare request present this cycle |
| cmp_rel | input | 2 | Relation select (see R5) |
| cmp_a | input | DATA_W | Operand A |
| cmp_b | input | DATA_W | Operand B |
| cmp_a_zero | input | 1 | Replace operand A with zero |
| cmp_b_zero | input | 1 | Replace operand B with zero |
| cmp_tgt_t | input | IDX_W | Predicate that receives the result |
| cmp_tgt_f | input | IDX_W | Predicate that receives the inverse result |
| cmp_qp | input | IDX_W | Qualifying predicate of the compare |
| op_qp | input | IDX_W | Qualifying predicate looked up for an issued operation |
| commit_en | output | 1 | Value of predicate `op_qp` |

## Verification
The hardest situation to reach from the ports is a qualified compare that overwrites a predicate while another compare depends on that same predicate as its qualifier. Only a chain of compares creates this case, and after reset almost every predicate is clear, so most random compares become no-ops. The stimulus first sets a spread of predicates with compares qualified by predicate 0. It then draws qualifiers from the range of recently written indices, so that qualified and unqualified compares interleave. A bench model tracks all predicates and a full lookup scan compares against it. Directed cases cover the same-target pair, writes to predicate 0, signed boundaries and lookups of a predicate in the cycle it is written.

// File: rtl/predf_pkg.sv
package predf_pkg;
   typedef enum logic [1:0] {
      REL_EQ = 2'd0,
      REL_NE = 2'd1,
      REL_LT = 2'd2,
      REL_GT = 2'd3
   } rel_e;
endpackage

// File: rtl/pred_relation.sv
// Evaluates the selected relation between two operands.
module pred_relation
   import predf_pkg::*;
#(
   parameter int DATA_W     = 64,
   parameter bit REL_SIGNED = 1'b1
) (
   input  rel_e              rel,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              a_zero,
   input  logic              b_zero,
   output logic              result
);
   logic [DATA_W-1:0] opa, opb;
   logic              is_eq, is_lt, is_gt;

   assign opa   = a_zero ? '0 : a;
   assign opb   = b_zero ? '0 : b;
   assign is_eq = (opa == opb);

   generate
      if (REL_SIGNED) begin : g_signed
         assign is_lt = $signed(opa) < $signed(opb);
         assign is_gt = $signed(opa) > $signed(opb);
      end else begin : g_unsigned
         assign is_lt = opa < opb;
         assign is_gt = opa > opb;
      end
   endgenerate

   always_comb begin
      unique case (rel)
         REL_EQ:  result = is_eq;
         REL_NE:  result = !is_eq;
         REL_LT:  result = is_lt;
         REL_GT:  result = is_gt;
         default: result = 1'b0;
      endcase
   end
endmodule

// File: rtl/pred_wr_decode.sv
// Turns the two target indices into per-entry write enables and data.
module pred_wr_decode #(
   parameter int NPRED = 64,
   parameter int IDX_W = $clog2(NPRED)
) (
   input  logic             wr_en,
   input  logic [IDX_W-1:0] idx_t,
   input  logic [IDX_W-1:0] idx_f,
   input  logic             result,
   output logic [NPRED-1:0] we,
   output logic [NPRED-1:0] wd
);
   generate
      for (genvar i = 0; i < NPRED; i++) begin : g_ent
         if (i == 0) begin : g_fixed
            assign we[i] = 1'b0;
            assign wd[i] = 1'b1;
         end else begin : g_rw
            logic hit_t, hit_f;
            assign hit_t = wr_en && (idx_t == IDX_W'(i));
            assign hit_f = wr_en && (idx_f == IDX_W'(i));
            assign we[i] = hit_t || hit_f;
            // the result target has priority over the inverse target
            assign wd[i] = hit_t ? result : !result;
         end
      end
   endgenerate
endmodule

// File: rtl/pred_store.sv
// Predicate storage with two read ports; entry 0 is a constant one.
module pred_store #(
   parameter int NPRED = 64,
   parameter int IDX_W = $clog2(NPRED)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPRED-1:0] we,
   input  logic [NPRED-1:0] wd,
   input  logic [IDX_W-1:0] rd_a_idx,
   input  logic [IDX_W-1:0] rd_b_idx,
   output logic             rd_a_val,
   output logic             rd_b_val,
   output logic [NPRED-1:0] bits_q
);
   generate
      for (genvar i = 0; i < NPRED; i++) begin : g_bit
         if (i == 0) begin : g_one
            assign bits_q[i] = 1'b1;
         end else begin : g_ff
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)    q <= 1'b0;
               else if (we[i]) q <= wd[i];
            end
            assign bits_q[i] = q;
         end
      end
   endgenerate

   assign rd_a_val = bits_q[rd_a_idx];
   assign rd_b_val = bits_q[rd_b_idx];
endmodule

// File: rtl/pred_file.sv
module pred_file
   import predf_pkg::*;
#(
   parameter int NPRED      = 64,
   parameter int DATA_W     = 64,
   parameter bit REL_SIGNED = 1'b1,
   localparam int IDX_W     = $clog2(NPRED)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_valid,
   input  logic [1:0]        cmp_rel,
   input  logic [DATA_W-1:0] cmp_a,
   input  logic [DATA_W-1:0] cmp_b,
   input  logic              cmp_a_zero,
   input  logic              cmp_b_zero,
   input  logic [IDX_W-1:0]  cmp_tgt_t,
   input  logic [IDX_W-1:0]  cmp_tgt_f,
   input  logic [IDX_W-1:0]  cmp_qp,
   input  logic [IDX_W-1:0]  op_qp,
   output logic              commit_en
);
   generate
      if (NPRED < 2 || (1 << IDX_W) != NPRED) begin : g_bad_npred
         $error("pred_file: NPRED must be a power of two of at least 2");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("pred_file: DATA_W must be at least 2");
      end
   endgenerate

   logic             cmp_result;
   logic             cmp_qual;
   logic             wr_en;
   logic [NPRED-1:0] we, wd;
   logic [NPRED-1:0] bits_q;

   pred_relation #(.DATA_W(DATA_W), .REL_SIGNED(REL_SIGNED)) u_rel (
      .rel    (rel_e'(cmp_rel)),
      .a      (cmp_a),
      .b      (cmp_b),
      .a_zero (cmp_a_zero),
      .b_zero (cmp_b_zero),
      .result (cmp_result)
   );

   assign wr_en = cmp_valid && cmp_qual;

   pred_wr_decode #(.NPRED(NPRED), .IDX_W(IDX_W)) u_dec (
      .wr_en  (wr_en),
      .idx_t  (cmp_tgt_t),
      .idx_f  (cmp_tgt_f),
      .result (cmp_result),
      .we     (we),
      .wd     (wd)
   );

   pred_store #(.NPRED(NPRED), .IDX_W(IDX_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (we),
      .wd       (wd),
      .rd_a_idx (op_qp),
      .rd_b_idx (cmp_qp),
      .rd_a_val (commit_en),
      .rd_b_val (cmp_qual),
      .bits_q   (bits_q)
   );
endmodule

// File: rtl/pred_file_chk.sv
module pred_file_chk #(
   parameter int NPRED = 64,
   parameter int IDX_W = $clog2(NPRED)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmp_valid,
   input logic [IDX_W-1:0] cmp_tgt_t,
   input logic [IDX_W-1:0] cmp_tgt_f,
   input logic [IDX_W-1:0] cmp_qp,
   input logic [NPRED-1:0] pred_q
);
   logic [NPRED-1:0] tmask;
   logic             fire;

   assign fire  = cmp_valid && pred_q[cmp_qp];
   assign tmask = fire ? ((NPRED'(1) << cmp_tgt_t) | (NPRED'(1) << cmp_tgt_f)) : '0;

   // R1, R7
   a_r7_p0_stays_set: assert property (@(posedge clk) disable iff (!rst_n)
      pred_q[0] == 1'b1);

   // R3
   a_r3_unqualified_noop: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && !pred_q[cmp_qp]) |=> $stable(pred_q));

   // R4
   a_r4_pair_complement: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && cmp_tgt_t != cmp_tgt_f && cmp_tgt_t != '0 && cmp_tgt_f != '0)
      |=> pred_q[$past(cmp_tgt_t)] != pred_q[$past(cmp_tgt_f)]);

   // R10
   a_r10_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pred_q ^ $past(pred_q)) & ~$past(tmask)) == '0);
endmodule

bind pred_file pred_file_chk #(.NPRED(NPRED)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmp_valid (cmp_valid),
   .cmp_tgt_t (cmp_tgt_t),
   .cmp_tgt_f (cmp_tgt_f),
   .cmp_qp    (cmp_qp),
   .pred_q    (bits_q)
);

// File: tb/sim_pred_file.sv
module sim_pred_file;
   localparam int NPRED  = 64;
   localparam int DATA_W = 64;
   localparam int IDX_W  = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmp_valid = 1'b0;
   logic [1:0]        cmp_rel = '0;
   logic [DATA_W-1:0] cmp_a = '0, cmp_b = '0;
   logic              cmp_a_zero = 1'b0, cmp_b_zero = 1'b0;
   logic [IDX_W-1:0]  cmp_tgt_t = '0, cmp_tgt_f = '0, cmp_qp = '0, op_qp = '0;
   logic              commit_en;

   int checks = 0;
   int errors = 0;
   logic model [NPRED];

   always #5 clk = ~clk;

   pred_file #(.NPRED(NPRED), .DATA_W(DATA_W)) u0 (
      .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_rel(cmp_rel),
      .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_a_zero(cmp_a_zero), .cmp_b_zero(cmp_b_zero),
      .cmp_tgt_t(cmp_tgt_t), .cmp_tgt_f(cmp_tgt_f), .cmp_qp(cmp_qp),
      .op_qp(op_qp), .commit_en(commit_en)
   );

   function automatic logic rel_eval(input logic [1:0] rel, input logic [DATA_W-1:0] a,
                                     input logic [DATA_W-1:0] b, input logic az, input logic bz);
      logic signed [DATA_W-1:0] x, y;
      x = az ? '0 : a;
      y = bz ? '0 : b;
      case (rel)
         2'd0:    return x == y;
         2'd1:    return x != y;
         2'd2:    return x < y;
         default: return x > y;
      endcase
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b (op_qp=%0d)", req, act, exp, op_qp);
      end
   endtask

   // look up one predicate and compare with the model
   task automatic probe(input string req, input int idx);
      @(negedge clk);
      op_qp = IDX_W'(idx);
      #1 check(req, commit_en, model[idx]);
   endtask

   task automatic scan(input string req);
      for (int i = 0; i < NPRED; i++) probe(req, i);
   endtask

   // one compare request; optional same-cycle lookup of probe_idx (R9)
   task automatic do_cmp(input logic [1:0] rel, input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                         input logic az, input logic bz, input int t, input int f, input int qp,
                         input int probe_idx);
      logic r;
      @(negedge clk);
      cmp_valid = 1'b1; cmp_rel = rel; cmp_a = a; cmp_b = b;
      cmp_a_zero = az; cmp_b_zero = bz;
      cmp_tgt_t = IDX_W'(t); cmp_tgt_f = IDX_W'(f); cmp_qp = IDX_W'(qp);
      if (probe_idx >= 0) begin
         op_qp = IDX_W'(probe_idx);
         #1 check("R9 old value during write", commit_en, model[probe_idx]);
      end
      @(posedge clk);
      r = rel_eval(rel, a, b, az, bz);
      if (model[qp]) begin
         if (f != 0) model[f] = !r;
         if (t != 0) model[t] = r;
      end
      @(negedge clk);
      cmp_valid = 1'b0;
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < NPRED; i++) model[i] = (i == 0);
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      scan("R1 reset state");

      // R5: each relation, signed boundaries
      do_cmp(2'd0, 64'd7, 64'd7, 0, 0, 1, 2, 0, -1);
      probe("R5 eq true", 1); probe("R4 complement", 2);
      do_cmp(2'd1, 64'd7, 64'd7, 0, 0, 3, 4, 0, -1);
      probe("R5 ne false", 3); probe("R4 complement", 4);
      do_cmp(2'd2, '1, 64'd1, 0, 0, 5, 6, 0, -1);
      probe("R5 signed lt -1<1", 5); probe("R4 complement", 6);
      do_cmp(2'd3, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0, 7, 8, 0, -1);
      probe("R5 signed gt min>max false", 7); probe("R4 complement", 8);
      // R6: zero operand
      do_cmp(2'd0, 64'd0, 64'hDEAD, 0, 1, 9, 10, 0, -1);
      probe("R6 b replaced by zero", 9);
      do_cmp(2'd2, 64'h55, 64'd3, 1, 0, 11, 12, 0, -1);
      probe("R6 a replaced by zero", 11);
      // R7: write to p0 ignored
      do_cmp(2'd1, 64'd1, 64'd1, 0, 0, 0, 13, 0, -1);
      probe("R7 p0 kept", 0); probe("R4 inverse still written", 13);
      // R8: same target
      do_cmp(2'd0, 64'd2, 64'd2, 0, 0, 14, 14, 0, -1);
      probe("R8 result wins", 14);
      do_cmp(2'd1, 64'd2, 64'd2, 0, 0, 14, 14, 0, -1);
      probe("R8 result wins", 14);
      // R3: qualifier clear (p2 is 0)
      do_cmp(2'd0, 64'd5, 64'd5, 0, 0, 2, 1, 2, -1);
      probe("R3 no change", 1); probe("R3 no change", 2);
      // R9: lookup during write
      do_cmp(2'd0, 64'd3, 64'd4, 0, 0, 1, 2, 0, 1);
      probe("R9 new value next cycle", 1);
      do_cmp(2'd0, 64'd3, 64'd3, 0, 0, 2, 1, 1, 2);
      probe("R2 lookup", 2);

      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [DATA_W-1:0] a, b;
         int t, f, q, p;
         a = {$urandom, $urandom};
         b = ($urandom_range(0, 2) == 0) ? a : {$urandom, $urandom};
         if ($urandom_range(0, 3) == 0) b = -a;
         t = $urandom_range(0, 31);
         f = ($urandom_range(0, 9) == 0) ? t : $urandom_range(0, 31);
         q = ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(0, 31);
         p = ($urandom_range(0, 3) == 0) ? t : -1;
         do_cmp(2'($urandom), a, b, $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
                t, f, q, p);
         probe("R4 random target", t);
         probe("R10 random other", $urandom_range(0, NPRED - 1));
      end
      scan("R10 final state");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule